// File: doc/BRIEF.md
# Erase and Protect Busy Sequencer

This host-side block runs one programming-type operation on a card and then waits until the card has finished it. The operation can be an erase of a selected group range, a write-protect set, a write-protect clear, or a re-selection of a card that may still be busy. For an erase, the sequencer first issues the group-start command with the start address. It then issues the group-end command with the end address, and then the erase command. Each of the other operations is a single command whose argument is the start value of the request.

Commands leave through a simple issue interface: an index, an argument and a one-cycle issue strobe. The sequencer then waits for a done flag from the command engine, qualified by a response-ok flag. After the last response the card holds DAT0 low while it works. The sequencer ignores DAT0 for two settling cycles and then samples it on every cycle. Release raises a one-cycle done pulse. A programmable number of low samples raises a timeout pulse instead. A rejected response at any step stops the sequence at once and raises a response-error pulse.

Top module: `erase_busy_seq`

## Requirements
- R1: After reset, and after a reset applied in the middle of an operation, req_ready is 1 and cmd_issue, done, err_resp and err_timeout are all 0.
- R2: A request (req_valid) is taken only in a cycle where req_ready is 1. A request raised while an operation runs has no effect: it causes no extra command issue.
- R3: For req_op 2'b00 (erase), three commands are issued in a fixed order. The first has index 35 and argument req_start_arg, the second has index 36 and argument req_end_arg, and the third has index 38 and argument 0. Each command is a one-cycle cmd_issue, and the next command is issued only after cmd_done with cmd_resp_ok set.
- R4: req_op 2'b01 issues one command with index 28, 2'b10 issues index 29, and 2'b11 issues index 7. In each case the argument is req_start_arg, and the busy wait follows.
- R5: When cmd_done comes with cmd_resp_ok equal to 0, err_resp is 1 for exactly the next cycle and req_ready is 1 in that same cycle. No later command of the sequence is issued.
- R6: DAT0 is ignored in the two cycles that follow the cycle of the final cmd_done. Sampling starts in the third cycle.
- R7: The first sample with DAT0 high makes done 1 in the next cycle, for exactly one cycle. req_ready is 0 while done is 1 and returns to 1 in the following cycle.
- R8: If DAT0 is low on req_limit consecutive samples, err_timeout is 1 for one cycle, in the cycle after the last of those samples, and done stays 0. A req_limit of 0 acts as 1.
- R9: If DAT0 is first seen high on the very sample that would otherwise reach the limit, the result is done and not err_timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is 1 |
| req_op | input | 2 | 00 erase, 01 protect set, 10 protect clear, 11 select |
| req_start_arg | input | 32 | Group-start address, or the argument of a single-command operation |
| req_end_arg | input | 32 | Group-end address (erase only) |
| req_limit | input | 24 | Busy timeout, counted in DAT0 samples |
| req_ready | output | 1 | Sequencer idle |
| cmd_issue | output | 1 | One-cycle command issue strobe |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_done | input | 1 | Command engine finished the current command |
| cmd_resp_ok | input | 1 | Response accepted, qualifies cmd_done |
| dat0 | input | 1 | DAT0 line, low while the card is busy |
| done | output | 1 | One-cycle pulse on busy release |
| err_resp | output | 1 | One-cycle pulse on a rejected response |
| err_timeout | output | 1 | One-cycle pulse on busy timeout |

## Verification
Busy release and timeout expiry can land on the same DAT0 sample. This happens when the line rises on exactly the sample whose count equals the limit. The table provokes it with a busy length of one less than the limit and expects a done pulse with no timeout. A neighbouring vector holds DAT0 low for exactly the limit and expects the timeout one cycle earlier than the release would have come. A second overlap is a new request raised while a wait is running. It is driven in the middle of each busy phase, and the bench judges it by the count of issued commands.

// File: rtl/ebs_pkg.sv
// Package: shared operation codes, command indices and sizes for the
// erase/protect busy sequencer. Assumes 6-bit command indices.
package ebs_pkg;

    localparam int IDX_W = 6;

    typedef enum logic [1:0] {
        OP_ERASE  = 2'b00,
        OP_WP_SET = 2'b01,
        OP_WP_CLR = 2'b10,
        OP_SELECT = 2'b11
    } ebs_op_e;

    localparam logic [IDX_W-1:0] IDX_GRP_START = 6'd35;
    localparam logic [IDX_W-1:0] IDX_GRP_END   = 6'd36;
    localparam logic [IDX_W-1:0] IDX_ERASE     = 6'd38;
    localparam logic [IDX_W-1:0] IDX_WP_SET    = 6'd28;
    localparam logic [IDX_W-1:0] IDX_WP_CLR    = 6'd29;
    localparam logic [IDX_W-1:0] IDX_SELECT    = 6'd7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT_RSP,
        ST_BUSY
    } seq_state_e;

    typedef enum logic [1:0] {
        BW_IDLE,
        BW_SETTLE,
        BW_SAMPLE
    } bw_phase_e;

endpackage

// File: rtl/ebs_cmd_plan.sv
// Module: ebs_cmd_plan
// Maps an operation and a step number to the command index and argument to
// issue, and flags the last step. Purely combinational.
// Assumes: step stays below the step count of the operation (3 for erase, 1 otherwise).
module ebs_cmd_plan
    import ebs_pkg::*;
#(
    parameter int AW = 32
) (
    input  ebs_op_e          op,
    input  logic [1:0]       step,
    input  logic [AW-1:0]    start_arg,
    input  logic [AW-1:0]    end_arg,
    output logic [IDX_W-1:0] index,
    output logic [AW-1:0]    arg,
    output logic             last
);

    localparam logic [1:0] ERASE_LAST = 2'd2;

    // Select the command for the current step of the operation.
    always_comb begin
        index = IDX_SELECT;
        arg   = start_arg;
        last  = 1'b1;
        case (op)
            OP_ERASE: begin
                last = (step == ERASE_LAST);
                case (step)
                    2'd0:    begin index = IDX_GRP_START; arg = start_arg;   end
                    2'd1:    begin index = IDX_GRP_END;   arg = end_arg;     end
                    default: begin index = IDX_ERASE;     arg = '0;          end
                endcase
            end
            OP_WP_SET: index = IDX_WP_SET;
            OP_WP_CLR: index = IDX_WP_CLR;
            default:   index = IDX_SELECT;
        endcase
    end

endmodule

// File: rtl/ebs_busy_wait.sv
// Module: ebs_busy_wait
// After a start pulse, waits SETTLE_CYC cycles and then samples dat0 on every
// cycle. It raises a one-cycle 'released' pulse on the first high sample, or a
// one-cycle 'timed_out' pulse after 'limit' consecutive low samples. A limit
// of 0 acts as 1, and a release wins over a timeout on the same sample.
// Assumes: start is raised only while active is low.
module ebs_busy_wait
    import ebs_pkg::*;
#(
    parameter int TO_W       = 24,
    parameter int SETTLE_CYC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            dat0,
    input  logic [TO_W-1:0] limit,
    output logic            active,
    output logic            released,
    output logic            timed_out
);

    localparam int SW = $clog2(SETTLE_CYC + 2);

    bw_phase_e       phase;
    logic [SW-1:0]   settle_cnt;
    logic [TO_W-1:0] low_cnt;
    logic [TO_W:0]   low_next;

    // Count of low samples, including the one taken in this cycle.
    assign low_next = {1'b0, low_cnt} + 1'b1;
    assign active   = (phase != BW_IDLE);

    // Settle, sample and time out the busy signal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= BW_IDLE;
            settle_cnt <= '0;
            low_cnt    <= '0;
            released   <= 1'b0;
            timed_out  <= 1'b0;
        end else begin
            released  <= 1'b0;
            timed_out <= 1'b0;
            case (phase)
                BW_IDLE: begin
                    low_cnt <= '0;
                    if (start) begin
                        settle_cnt <= SW'(SETTLE_CYC);
                        phase      <= (SETTLE_CYC == 0) ? BW_SAMPLE : BW_SETTLE;
                    end
                end
                BW_SETTLE: begin
                    if (settle_cnt <= SW'(1)) phase <= BW_SAMPLE;
                    else                      settle_cnt <= settle_cnt - 1'b1;
                end
                BW_SAMPLE: begin
                    if (dat0) begin
                        released <= 1'b1;
                        phase    <= BW_IDLE;
                    end else if (low_next >= {1'b0, limit}) begin
                        timed_out <= 1'b1;
                        phase     <= BW_IDLE;
                    end else begin
                        low_cnt <= low_next[TO_W-1:0];
                    end
                end
                default: phase <= BW_IDLE;
            endcase
        end
    end

    AST_RELEASE_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        released |-> $past(dat0));                               // R7
    AST_TIMEOUT_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        timed_out |-> !$past(dat0));                             // R9
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(released && timed_out));                               // R8
    AST_SETTLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == BW_SETTLE) |=> !released && !timed_out);      // R6

endmodule

// File: rtl/erase_busy_seq.sv
// Module: erase_busy_seq
// Runs an erase (three commands), a protect set or clear, or a select
// (one command each) through a command-issue interface. It then waits for the
// card's DAT0 busy to end, with a settle delay and a sample-count timeout.
// Assumes: cmd_done comes only after cmd_issue and is qualified by cmd_resp_ok.
module erase_busy_seq
    import ebs_pkg::*;
#(
    parameter int AW         = 32,
    parameter int TO_W       = 24,
    parameter int SETTLE_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [AW-1:0]    req_start_arg,
    input  logic [AW-1:0]    req_end_arg,
    input  logic [TO_W-1:0]  req_limit,
    output logic             req_ready,
    output logic             cmd_issue,
    output logic [IDX_W-1:0] cmd_index,
    output logic [AW-1:0]    cmd_arg,
    input  logic             cmd_done,
    input  logic             cmd_resp_ok,
    input  logic             dat0,
    output logic             done,
    output logic             err_resp,
    output logic             err_timeout
);

    seq_state_e       state;
    ebs_op_e          op_q;
    logic [1:0]       step_q;
    logic [AW-1:0]    start_q;
    logic [AW-1:0]    end_q;
    logic [TO_W-1:0]  limit_q;
    logic             last_step;
    logic             busy_start;
    logic             busy_active;
    logic             busy_release;
    logic             busy_timeout;

    ebs_cmd_plan #(.AW(AW)) u_plan (
        .op        (op_q),
        .step      (step_q),
        .start_arg (start_q),
        .end_arg   (end_q),
        .index     (cmd_index),
        .arg       (cmd_arg),
        .last      (last_step)
    );

    ebs_busy_wait #(.TO_W(TO_W), .SETTLE_CYC(SETTLE_CYC)) u_busy (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (busy_start),
        .dat0      (dat0),
        .limit     (limit_q),
        .active    (busy_active),
        .released  (busy_release),
        .timed_out (busy_timeout)
    );

    // Outputs taken from the state and from the busy waiter.
    assign req_ready   = (state == ST_IDLE);
    assign cmd_issue   = (state == ST_ISSUE);
    assign busy_start  = (state == ST_WAIT_RSP) && cmd_done && cmd_resp_ok && last_step;
    assign done        = busy_release;
    assign err_timeout = busy_timeout;

    // Step through the commands and hand the final wait to the busy waiter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_q     <= OP_ERASE;
            step_q   <= '0;
            start_q  <= '0;
            end_q    <= '0;
            limit_q  <= '0;
            err_resp <= 1'b0;
        end else begin
            err_resp <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q    <= ebs_op_e'(req_op);
                        step_q  <= '0;
                        start_q <= req_start_arg;
                        end_q   <= req_end_arg;
                        limit_q <= req_limit;
                        state   <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state <= ST_WAIT_RSP;
                ST_WAIT_RSP: begin
                    if (cmd_done) begin
                        if (!cmd_resp_ok) begin
                            err_resp <= 1'b1;
                            state    <= ST_IDLE;
                        end else if (last_step) begin
                            state <= ST_BUSY;
                        end else begin
                            step_q <= step_q + 1'b1;
                            state  <= ST_ISSUE;
                        end
                    end
                end
                ST_BUSY: begin
                    if (busy_release || busy_timeout) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Remember the last index issued, for the ordering checks below.
    logic [IDX_W-1:0] prev_idx;
    always_ff @(posedge clk) begin
        if (!rst_n)         prev_idx <= '0;
        else if (cmd_issue) prev_idx <= cmd_index;
    end

    AST_ISSUE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue |=> !cmd_issue);                                       // R3
    AST_END_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_issue && cmd_index == IDX_GRP_END) |-> prev_idx == IDX_GRP_START); // R3
    AST_ERASE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_issue && cmd_index == IDX_ERASE) |-> prev_idx == IDX_GRP_END);     // R3
    AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_issue && !busy_active);                       // R2
    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);                                            // R7
    AST_ERR_RESP_READY: assert property (@(posedge clk) disable iff (!rst_n)
        err_resp |-> req_ready && !busy_active);                         // R5

endmodule

// File: tb/test_erase_busy_seq.sv
`timescale 1ns/1ps
module test_erase_busy_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [31:0] req_start_arg = '0;
    logic [31:0] req_end_arg = '0;
    logic [23:0] req_limit = '0;
    logic        req_ready;
    logic        cmd_issue;
    logic [5:0]  cmd_index;
    logic [31:0] cmd_arg;
    logic        cmd_done = 1'b0;
    logic        cmd_resp_ok = 1'b0;
    logic        dat0 = 1'b1;
    logic        done;
    logic        err_resp;
    logic        err_timeout;

    int checks = 0;
    int errors = 0;
    int issue_cnt = 0;

    always #2.5 clk = ~clk;

    erase_busy_seq i_erase_busy_seq (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_op (req_op),
        .req_start_arg (req_start_arg), .req_end_arg (req_end_arg),
        .req_limit (req_limit), .req_ready (req_ready), .cmd_issue (cmd_issue),
        .cmd_index (cmd_index), .cmd_arg (cmd_arg), .cmd_done (cmd_done),
        .cmd_resp_ok (cmd_resp_ok), .dat0 (dat0), .done (done),
        .err_resp (err_resp), .err_timeout (err_timeout)
    );

    // Count every command strobe the design emits.
    always @(posedge clk) if (rst_n && cmd_issue) issue_cnt++;

    typedef struct packed {
        logic [1:0] op;
        logic [1:0] fail;   // step whose response fails, 3 = none
        logic [7:0] lim;
        logic [7:0] busy;   // number of low DAT0 samples
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'd3, 8'd10, 8'd3},   // erase, release            R3 R7
        '{2'd1, 2'd3, 8'd5,  8'd0},   // protect set, no busy      R4
        '{2'd2, 2'd3, 8'd4,  8'd4},   // protect clear, timeout    R8
        '{2'd3, 2'd3, 8'd6,  8'd5},   // select, release on limit  R9
        '{2'd0, 2'd1, 8'd8,  8'd0},   // erase, fails at step 1    R5
        '{2'd0, 2'd0, 8'd8,  8'd0},   // erase, fails at step 0    R5
        '{2'd0, 2'd3, 8'd3,  8'd9},   // erase, timeout            R8
        '{2'd1, 2'd3, 8'd0,  8'd1},   // limit 0 acts as 1         R8
        '{2'd0, 2'd3, 8'd9,  8'd2}    // settle ignored            R6
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_idx(input logic [1:0] op, input int s);
        case (op)
            2'd0:    return (s == 0) ? 6'd35 : (s == 1) ? 6'd36 : 6'd38;
            2'd1:    return 6'd28;
            2'd2:    return 6'd29;
            default: return 6'd7;
        endcase
    endfunction

    task automatic wait_issue(output bit seen);
        seen = 1'b0;
        for (int w = 0; w < 40; w++) begin
            @(negedge clk);
            req_valid = 1'b0;
            cmd_done  = 1'b0;
            if (cmd_issue) begin seen = 1'b1; break; end
        end
    endtask

    task automatic run_vec(input int i);
        vec_t v = VEC[i];
        int n = (v.op == 2'd0) ? 3 : 1;
        logic [31:0] sa = 32'h1000_0000 + i;
        logic [31:0] ea = 32'h2000_0000 + i;
        int base = issue_cnt;
        int eff_lim = (v.lim == 0) ? 1 : int'(v.lim);
        int exp_k;
        int got_k = -1;
        bit got_done = 0;
        bit seen;
        @(negedge clk);
        chk("R2", "ready before request", req_ready, 1);
        req_valid = 1'b1; req_op = v.op; req_start_arg = sa;
        req_end_arg = ea; req_limit = 24'(v.lim);
        for (int s = 0; s < n; s++) begin
            wait_issue(seen);
            chk(v.op == 0 ? "R3" : "R4", "issue seen", seen, 1);
            chk(v.op == 0 ? "R3" : "R4", "index", cmd_index, exp_idx(v.op, s));
            chk(v.op == 0 ? "R3" : "R4", "arg", cmd_arg,
                (v.op == 0 && s == 1) ? ea : (v.op == 0 && s == 2) ? 32'h0 : sa);
            @(negedge clk);
            cmd_done = 1'b1;
            cmd_resp_ok = (s != int'(v.fail));
            if (s == int'(v.fail)) begin
                @(negedge clk);
                cmd_done = 1'b0;
                chk("R5", "err_resp pulse", err_resp, 1);
                chk("R5", "ready with err_resp", req_ready, 1);
                repeat (6) @(negedge clk);
                chk("R5", "err_resp single", err_resp, 0);
                chk("R5", "no later issue", issue_cnt - base, s + 1);
                return;
            end
        end
        exp_k = (int'(v.busy) < eff_lim) ? int'(v.busy) + 4 : eff_lim + 3;
        for (int k = 1; k < 300; k++) begin
            @(negedge clk);
            cmd_done = 1'b0;
            if (k == 3) begin req_valid = 1'b1; req_op = 2'd3; end
            if (k == 4) req_valid = 1'b0;
            if (done || err_timeout) begin
                got_k = k; got_done = done;
                chk("R7", "not ready during pulse", req_ready, 0);
                break;
            end
            dat0 = (k <= 2) ? 1'b1 : ((k - 3) < int'(v.busy)) ? 1'b0 : 1'b1;
        end
        req_valid = 1'b0;
        chk((v.busy < v.lim) ? "R9" : "R8", "result is done",
            got_done, int'(v.busy) < eff_lim);
        chk(i == 8 ? "R6" : (got_done ? "R7" : "R8"), "result cycle", got_k, exp_k);
        @(negedge clk);
        dat0 = 1'b1;
        chk("R7", "pulse single", done | err_timeout, 0);
        chk("R7", "ready after pulse", req_ready, 1);
        chk("R2", "busy-time request ignored", issue_cnt - base, n);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", req_ready, 1);
        chk("R1", "outputs idle", {cmd_issue, done, err_resp, err_timeout}, 0);
        for (int i = 0; i < NV; i++) run_vec(i);
        // Reset applied in the middle of an erase.
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_start_arg = 32'h55; req_limit = 24'd5;
        wait_issue(seen);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after mid reset", req_ready, 1);
        chk("R1", "idle after mid reset", {cmd_issue, done, err_resp, err_timeout}, 0);
        run_vec(1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule